// File: doc/BRIEF.md
# Sparse-Recovery Iteration Statistics Unit

The block runs alongside the matrix-product datapath of an iterative sparse-recovery engine and produces the scalars for each iteration. While the residual vector streams in, it keeps a running sum of squares. While the current estimate streams in, it applies soft thresholding to each element using the threshold from the previous iteration. It also counts the elements that survive thresholding.

When the vector ends, a multi-cycle digit-serial square root turns the mean square into the residual RMSE. The unit then forms the next threshold by scaling the RMSE with a power-of-two regularization factor chosen at run time. It compares the same RMSE against an early-termination level and derives the correction weight from the survivor count. All results appear together on a single-cycle publish strobe and are held until the next one.

Samples are signed 26-bit values with 13 fraction bits, and a vector holds M = 512 elements.

Top module: `amp_stats_unit`

## Requirements
- R1: After reset, out_valid, busy, stat_valid and et_flag are 0, and rmse, tau, nz_count and b_weight are 0.
- R2: One cycle after a cycle with est_valid high, out_valid is high and out_data = sign(x)·max(|x|−tau, 0), where x is est_data and tau is the threshold currently published. out_valid is low one cycle after a cycle with est_valid low.
- R3: nz_count is the number of est_valid samples with |x| > tau accepted since the last vec_start. b_weight equals nz_count shifted left by 4, which is nz_count/512 with 13 fraction bits.
- R4: The sum of squares covers res_valid samples since the last vec_start. A sample in the same cycle as vec_start is the first sample of the new vector. A sample in the same cycle as vec_done is included.
- R5: rmse = floor(sqrt(floor(S/512))), where S is the integer sum of squares. This gives an RMSE with 13 fraction bits.
- R6: tau = min(floor(rmse·2^(k−3)), 2047), where k is lam_sel and lam_sel values 6 and 7 act as 5. So k = 0..5 selects a factor of 1/8 to 4. lam_sel and gamma are sampled in the cycle vec_done is accepted.
- R7: et_flag = 1 exactly when gamma ≠ 0 and rmse ≤ gamma, with gamma on the same 13-fraction-bit scale. gamma = 0 never raises the flag.
- R8: busy rises in the cycle after an accepted vec_done and stays high for 26 cycles. stat_valid pulses for one cycle as busy falls. rmse, tau, nz_count, b_weight and et_flag change only on that pulse.
- R9: A vec_done while busy is high is ignored. No second computation starts and no extra stat_valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_start | input | 1 | Clears the sum of squares and the survivor count |
| vec_done | input | 1 | Ends the vector and starts the square root |
| res_valid | input | 1 | Residual sample strobe |
| res_data | input | 26 | Signed residual sample |
| est_valid | input | 1 | Estimate sample strobe |
| est_data | input | 26 | Signed estimate sample |
| lam_sel | input | 3 | Regularization shift code |
| gamma | input | 16 | Early-termination level, 13 fraction bits |
| out_valid | output | 1 | Thresholded sample strobe |
| out_data | output | 26 | Signed thresholded sample |
| busy | output | 1 | Square root in progress |
| stat_valid | output | 1 | Publish strobe for the scalars |
| rmse | output | 26 | Residual RMSE |
| tau | output | 11 | Threshold |
| nz_count | output | 10 | Survivor count |
| b_weight | output | 14 | Correction weight |
| et_flag | output | 1 | Early-termination flag |

## Verification
The residual and estimate streams are driven in the same cycles, so thresholding and counting overlap with accumulation. vec_start coincides with the first sample and vec_done with the last, so the clear and the final accumulation share a cycle with live data. The bench computes the expected sum, integer square root, scaled threshold and survivor count itself. It judges every output sample against the previously published threshold. A second vec_done is injected mid-computation to show that it neither restarts the square root nor produces an extra pulse.

// File: rtl/amp_stats_unit.sv
module amp_stats_unit #(
  parameter int DW   = 26,
  parameter int FRAC = 13,
  parameter int M    = 512,
  parameter int TW   = 11,
  parameter int GW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vec_start,
  input  logic                    vec_done,
  input  logic                    res_valid,
  input  logic signed [DW-1:0]    res_data,
  input  logic                    est_valid,
  input  logic signed [DW-1:0]    est_data,
  input  logic [2:0]              lam_sel,
  input  logic [GW-1:0]           gamma,
  output logic                    out_valid,
  output logic signed [DW-1:0]    out_data,
  output logic                    busy,
  output logic                    stat_valid,
  output logic [DW-1:0]           rmse,
  output logic [TW-1:0]           tau,
  output logic [$clog2(M):0]      nz_count,
  output logic [FRAC:0]           b_weight,
  output logic                    et_flag
);
  localparam int LOG2M = $clog2(M);
  localparam int ACCW  = 2*DW + LOG2M;
  localparam int RW    = 2*DW;
  localparam int QW    = RW/2;
  localparam int CW    = LOG2M + 1;
  localparam int SW    = $clog2(QW+1);

  // residual sum of squares
  logic signed [2*DW-1:0] sq;
  logic [ACCW-1:0]        acc, acc_nx;
  assign sq     = res_data * res_data;
  assign acc_nx = (vec_start ? '0 : acc) + (res_valid ? ACCW'($unsigned(sq)) : '0);

  // soft threshold and survivor count
  logic [DW:0]    mag, diff, sgn_diff;
  logic           above;
  logic [CW-1:0]  cnt, cnt_base, cnt_nx;
  assign mag      = est_data[DW-1] ? (~{1'b1, est_data} + 1'b1) : {1'b0, est_data};
  assign above    = mag > (DW+1)'(tau);
  assign diff     = mag - (DW+1)'(tau);
  assign sgn_diff = est_data[DW-1] ? (~diff + 1'b1) : diff;
  assign cnt_base = vec_start ? '0 : cnt;
  assign cnt_nx   = (cnt_base == {CW{1'b1}}) ? cnt_base : cnt_base + CW'(est_valid && above);

  // digit-serial square root
  logic [RW-1:0]  rad;
  logic [QW:0]    rem, rem_nx;
  logic [QW-1:0]  root, root_nx;
  logic [QW+2:0]  rem_sh, trial;
  logic           ge;
  logic [SW-1:0]  step;
  logic [CW-1:0]  cnt_snap;
  logic [2:0]     lam_q;
  logic [GW-1:0]  gamma_q;
  assign rem_sh  = {rem, rad[RW-1:RW-2]};
  assign trial   = {1'b0, root, 2'b01};
  assign ge      = rem_sh >= trial;
  assign rem_nx  = ge ? (QW+1)'(rem_sh - trial) : rem_sh[QW:0];
  assign root_nx = {root[QW-2:0], ge};

  // threshold scaling
  logic [DW+1:0] scaled;
  logic [TW-1:0] tau_nx;
  assign scaled = {root_nx, 2'b00} >> (3'd5 - lam_q);
  assign tau_nx = (scaled > (DW+2)'({TW{1'b1}})) ? {TW{1'b1}} : scaled[TW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; cnt <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      acc <= acc_nx;
      cnt <= cnt_nx;
      out_valid <= est_valid;
      if (est_valid) out_data <= above ? sgn_diff[DW-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stat_valid <= 1'b0; step <= '0;
      rad <= '0; rem <= '0; root <= '0;
      cnt_snap <= '0; lam_q <= '0; gamma_q <= '0;
      rmse <= '0; tau <= '0; nz_count <= '0; b_weight <= '0; et_flag <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      if (busy) begin
        rem  <= rem_nx;
        root <= root_nx;
        rad  <= rad << 2;
        step <= step + 1'b1;
        if (step == SW'(QW-1)) begin
          busy       <= 1'b0;
          stat_valid <= 1'b1;
          rmse       <= root_nx;
          tau        <= tau_nx;
          nz_count   <= cnt_snap;
          b_weight   <= (FRAC+1)'(cnt_snap) << (FRAC-LOG2M);
          et_flag    <= (gamma_q != '0) && (64'(root_nx) <= 64'(gamma_q));
        end
      end else if (vec_done) begin
        busy     <= 1'b1;
        step     <= '0;
        rad      <= acc_nx[ACCW-1:LOG2M];
        rem      <= '0;
        root     <= '0;
        cnt_snap <= cnt_nx;
        lam_q    <= (lam_sel > 3'd5) ? 3'd5 : lam_sel;
        gamma_q  <= gamma;
      end
    end
  end

  assert_out_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> out_valid);
  assert_out_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> (out_data == '0 || out_data[DW-1] == $past(est_data[DW-1])));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vec_done));
  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($past(busy) && !busy));
  assert_scalars_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> ($stable(tau) && $stable(rmse) && $stable(nz_count) && $stable(et_flag)));
endmodule

// File: tb/tb_amp_stats_unit.sv
`timescale 1ns/1ps
module tb_amp_stats_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vec_start = 0, vec_done = 0, res_valid = 0, est_valid = 0;
  logic signed [25:0] res_data = '0, est_data = '0;
  logic [2:0] lam_sel = '0;
  logic [15:0] gamma = '0;
  logic out_valid, busy, stat_valid, et_flag;
  logic signed [25:0] out_data;
  logic [25:0] rmse;
  logic [10:0] tau;
  logic [9:0] nz_count;
  logic [13:0] b_weight;

  int checks = 0, fails = 0;
  longint cur_tau = 0;

  amp_stats_unit dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint q);
    longint r = longint'($floor($sqrt(real'(q))));
    while (r > 0 && r*r > q) r--;
    while ((r+1)*(r+1) <= q) r++;
    return r;
  endfunction

  function automatic longint res_val(input int it, input int i);
    case (it % 5)
      0: return 0;
      1: return ((i*37 + it) % 201) - 100;
      2: return (i % 2) ? 33554431 : -33554432;
      3: return (((i*7919) % 8192) - 4096) * 64;
      default: return ((i*3) % 61) - 30;
    endcase
  endfunction

  function automatic longint est_val(input int it, input int i, input longint t);
    case (i)
      0: return -33554432;
      1: return 33554431;
      2: return t;
      3: return t + 1;
      4: return -t;
      5: return -(t + 1);
      6: return 0;
      default: return ((i*13 + it*5) % 4001) - 2000;
    endcase
  endfunction

  task automatic run_iter(input int it, input int sel, input int gmode, input bit extra_done);
    longint s = 0, r = 0, g = 0, e, a, exp_o, sc, etau;
    int nz = 0, bc = 0, k;
    for (int i = 0; i < 512; i++) begin
      longint rv = res_val(it, i);
      e = est_val(it, i, cur_tau);
      s += rv * rv;
      res_valid = 1; res_data = 26'(rv);
      est_valid = 1; est_data = 26'(e);
      vec_start = (i == 0);
      vec_done  = (i == 511);
      if (i == 511) begin
        r = isqrt(s >>> 9);
        g = (gmode == 0) ? 0 : (gmode == 1) ? ((r > 65535) ? 65535 : r) : ((r > 0) ? ((r - 1 > 65535) ? 65535 : r - 1) : 1);
        gamma = 16'(g); lam_sel = 3'(sel);
      end
      @(negedge clk);
      a = (e < 0) ? -e : e;
      exp_o = (a > cur_tau) ? ((e < 0) ? -(a - cur_tau) : (a - cur_tau)) : 0;
      if (a > cur_tau) nz++;
      check(out_valid == 1'b1, "R2 out_valid", out_valid, 1);
      check(longint'(out_data) == exp_o, "R2 soft threshold", longint'(out_data), exp_o);
    end
    res_valid = 0; est_valid = 0; vec_start = 0; vec_done = 0;
    while (!stat_valid && bc < 100) begin
      if (busy) bc++;
      vec_done = extra_done && (bc == 3);
      @(negedge clk);
      vec_done = 0;
    end
    check(bc == 26, "R8 busy length", bc, 26);
    check(stat_valid == 1'b1 && busy == 1'b0, "R8 publish pulse", stat_valid, 1);
    check(!out_valid, "R2 out_valid low", out_valid, 0);
    k = (sel > 5) ? 5 : sel;
    sc = (r * 4) >>> (5 - k);
    etau = (sc > 2047) ? 2047 : sc;
    check(longint'(rmse) == r, "R5 R4 rmse", rmse, r);
    check(longint'(tau) == etau, "R6 tau", tau, etau);
    check(longint'(nz_count) == nz, "R3 nz_count", nz_count, nz);
    check(longint'(b_weight) == nz * 16, "R3 b_weight", b_weight, nz * 16);
    check(et_flag == (g != 0 && r <= g), "R7 et_flag", et_flag, (g != 0 && r <= g));
    cur_tau = etau;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      check(!stat_valid && !busy, "R9 R8 no extra computation", {stat_valid, busy}, 0);
      check(longint'(tau) == etau, "R8 tau held", tau, etau);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && !busy && !stat_valid && !et_flag, "R1 reset flags", {out_valid, busy, stat_valid, et_flag}, 0);
    check(rmse == 0 && tau == 0, "R1 reset rmse tau", tau, 0);
    check(nz_count == 0 && b_weight == 0, "R1 reset count", nz_count, 0);
    for (int it = 0; it < 12; it++) run_iter(it, it % 8, it % 3, it == 4 || it == 9);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule